// File: doc/BRIEF.md
# Bit-Programmable GPIO Port Controller

This block is an 8-bit general-purpose I/O port. Each bit is set as an input or an output on its own. A simple register bus gives access to four registers: input data, output data, direction, and a per-bit drive-mode register. The drive-mode register picks push-pull or open-drain drive for bits that are outputs. The pads are outside the block, so the pin side is a pin input vector, a pin output vector and an output-enable vector.

Pin levels go through a two-flop synchronizer and then into the input-data register. Software may write the input-data register. On a bit set as an input, the next synchronized sample replaces the written value. On a bit set as an output, the written value stays, because output bits do not sample their pin. A read of the output-data register returns the value software stored, whatever level the pin actually shows.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and `pin_oe` and `pin_out` are 0x00, so every pin starts as a released input.
- R2: A write to address 2 sets the direction register on the write's clock edge. Bit value 1 makes that pin an output and 0 makes it an input. The register reads back the written value.
- R3: On an input bit, a change on `pin_in` is not visible in a read of address 0 after the first or second rising edge. It becomes visible after the third rising edge (two synchronizer flops, then the input register).
- R4: On an input bit, a software write to address 0 does not last. When the write and a synchronized sample land in the same cycle, the sample wins, and the read shows the synchronized pin value.
- R5: On an output bit, the input register ignores `pin_in`. It keeps the last value written to address 0.
- R6: A read of address 1 returns the stored output data, independent of `pin_in`.
- R7: On a bit with direction 1 and mode 0 (push-pull), `pin_oe` is 1 and `pin_out` equals the output-data bit, from the edge after the write.
- R8: On a bit with direction 1 and mode 1 (open-drain), `pin_out` is 0. `pin_oe` is 1 only when the output-data bit is 0.
- R9: On a bit with direction 0, `pin_oe` and `pin_out` are both 0, whatever the output-data and mode bits hold.
- R10: The address map is 0 input data, 1 output data, 2 direction, 3 drive mode. `reg_rdata` is combinational from `reg_addr`. A write changes only the addressed register, and any register may be accessed at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the addressed register |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Level to drive on each pin |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A stale or corrupted direction bit shows on `pin_oe` at the first negedge after the write edge. A wrong drive-mode bit shows the same way on the combination of `pin_out` and `pin_oe`. A broken synchronizer or input-register update shows as a pin change that reaches a read of address 0 one cycle early, one cycle late, or never. A wrongly held or lost input-register bit shows in the first read after a write or pin change: a written value survives on an input bit, or an output bit follows the pin. Each of these is sampled one edge after the cause, so the bench can tie every failure to the cycle that produced it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_INDATA  = 2'd0,
    ADDR_OUTDATA = 2'd1,
    ADDR_DIR     = 2'd2,
    ADDR_MODE    = 2'd3
  } gpio_addr_e;

  // Drive-mode value that selects open-drain on an output bit
  localparam logic MODE_OPEN_DRAIN = 1'b1;

  // Output enable of one bit from its direction, mode and data
  function automatic logic bit_drive_oe(input logic is_out, input logic mode, input logic data);
    if (!is_out)                  return 1'b0;
    if (mode == MODE_OPEN_DRAIN)  return ~data;
    return 1'b1;
  endfunction

  // Driven level of one bit
  function automatic logic bit_drive_level(input logic is_out, input logic mode, input logic data);
    if (!is_out)                  return 1'b0;
    if (mode == MODE_OPEN_DRAIN)  return 1'b0;
    return data;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= raw_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // Each stage carries exactly what the stage before it held one edge earlier
  generate
    if (STAGES >= 2) begin : g_chk
      assert_sync_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
    end
  endgenerate
  assert_first_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[0] == $past(raw_in));

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] mode,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pad_oe[b]  = bit_drive_oe(dir[b], mode[b], data[b]);
      assign pad_out[b] = bit_drive_level(dir[b], mode[b], data[b]);
    end
  endgenerate

  always_comb begin
    assert_no_drive_on_inputs_R9: assert ((pad_oe & ~dir) == '0 && (pad_out & ~dir) == '0);
    assert_od_never_high_R8: assert ((pad_out & mode) == '0);
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  logic [WIDTH-1:0] dir_q, outd_q, mode_q, ind_q, ind_next;
  logic [WIDTH-1:0] sync_val;

  // Named write events, one per register
  logic wr_ind, wr_outd, wr_dir, wr_mode;
  assign wr_ind  = reg_wr && (reg_addr == ADDR_INDATA);
  assign wr_outd = reg_wr && (reg_addr == ADDR_OUTDATA);
  assign wr_dir  = reg_wr && (reg_addr == ADDR_DIR);
  assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pin_in),
    .sync_out (sync_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      outd_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= reg_wdata;
      if (wr_outd) outd_q <= reg_wdata;
      if (wr_mode) mode_q <= reg_wdata;
    end
  end

  // Input bits always take the sample (it wins over a write); output bits hold or take the write
  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      if (!dir_q[b])   ind_next[b] = sync_val[b];
      else if (wr_ind) ind_next[b] = reg_wdata[b];
      else             ind_next[b] = ind_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ind_q <= '0;
    else        ind_q <= ind_next;
  end

  always_comb begin
    case (reg_addr)
      ADDR_INDATA:  reg_rdata = ind_q;
      ADDR_OUTDATA: reg_rdata = outd_q;
      ADDR_DIR:     reg_rdata = dir_q;
      default:      reg_rdata = mode_q;
    endcase
  end

  gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
    .dir     (dir_q),
    .mode    (mode_q),
    .data    (outd_q),
    .pad_out (pin_out),
    .pad_oe  (pin_oe)
  );

  assert_dir_write_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_dir) |-> dir_q == $past(reg_wdata));

  assert_input_bits_follow_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ind_q ^ $past(sync_val)) & ~$past(dir_q)) == '0);

  assert_output_bits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ind) |-> ((ind_q ^ $past(ind_q)) & $past(dir_q)) == '0);

  assert_unaddressed_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_mode) |-> $stable(mode_q));

  assert_pushpull_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ dir_q) & dir_q & ~mode_q) == '0);

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .pin_in, .pin_out, .pin_oe
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] exp_oe(input logic [7:0] d, input logic [7:0] m, input logic [7:0] o);
    return d & ~(m & o);
  endfunction

  function automatic logic [7:0] exp_out(input logic [7:0] d, input logic [7:0] m, input logic [7:0] o);
    return d & ~m & o;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] dpat [4];
    logic [7:0] mpat [4];
    logic [7:0] vals [5];
    dpat = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    mpat = '{8'h00, 8'hFF, 8'h0F, 8'h96};
    vals = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h81};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_check("R1 reset register", 2'(a), 8'h00);
    check("R1 reset oe", pin_oe, 8'h00);
    check("R1 reset out", pin_out, 8'h00);

    // R2 direction write and readback
    wr(2'd2, 8'hC3);
    rd_check("R2 dir readback", 2'd2, 8'hC3);
    check("R2 dir drives oe", pin_oe, 8'hC3);
    wr(2'd2, 8'h00);

    // R3 synchronizer latency, several patterns
    for (int i = 0; i < 5; i++) begin
      logic [7:0] old;
      reg_addr = 2'd0; #1; old = reg_rdata;
      @(negedge clk); pin_in = vals[i];
      @(negedge clk); rd_check("R3 after edge 1", 2'd0, old);
      @(negedge clk); rd_check("R3 after edge 2", 2'd0, old);
      @(negedge clk); rd_check("R3 after edge 3", 2'd0, vals[i]);
    end

    // R4 write to input bits loses to the sample
    pin_in = 8'h5A;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'hFF);
    rd_check("R4 input write overwritten", 2'd0, 8'h5A);
    wr(2'd0, 8'h00);
    rd_check("R4 input write overwritten zero", 2'd0, 8'h5A);

    // R5 output bits keep the written value, input bits follow the pin
    wr(2'd2, 8'hF0);
    pin_in = 8'hA5;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h3C);
    rd_check("R5 mixed after write", 2'd0, 8'h35);
    pin_in = 8'h0F;
    repeat (4) @(negedge clk);
    rd_check("R5 output bits hold vs pin", 2'd0, 8'h3F);
    wr(2'd2, 8'h00);

    // R6 output register read independent of the pin
    wr(2'd1, 8'h96);
    pin_in = 8'h69;
    repeat (4) @(negedge clk);
    rd_check("R6 outdata readback", 2'd1, 8'h96);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    rd_check("R6 outdata readback pin low", 2'd1, 8'h96);

    // R7 R8 R9 drive sweep
    for (int di = 0; di < 4; di++) begin
      for (int mi = 0; mi < 4; mi++) begin
        wr(2'd2, dpat[di]);
        wr(2'd3, mpat[mi]);
        for (int o = 0; o < 256; o++) begin
          wr(2'd1, 8'(o));
          #1;
          // R7 push-pull, R8 open-drain, R9 input bits released
          check("R7 R8 R9 oe", pin_oe, exp_oe(dpat[di], mpat[mi], 8'(o)));
          check("R7 R8 R9 out", pin_out, exp_out(dpat[di], mpat[mi], 8'(o)));
        end
      end
    end

    // R10 address map and write isolation
    wr(2'd2, 8'h12);
    wr(2'd1, 8'h34);
    wr(2'd3, 8'h56);
    rd_check("R10 dir kept", 2'd2, 8'h12);
    rd_check("R10 outdata kept", 2'd1, 8'h34);
    rd_check("R10 mode kept", 2'd3, 8'h56);
    wr(2'd0, 8'hFF);
    rd_check("R10 indata write leaves dir", 2'd2, 8'h12);
    rd_check("R10 indata write leaves outdata", 2'd1, 8'h34);
    rd_check("R10 indata write leaves mode", 2'd3, 8'h56);
    // output bits 4 and 1 took the write, input bits hold pin 0x00
    rd_check("R10 indata value", 2'd0, 8'h12);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule